// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Direct Routing

This block gathers 32 level-sensitive interrupt lines and folds every line that is enabled in a mask register into one summary request. That summary request feeds one input of a primary interrupt controller. The block can also give each source in the band 21 to 30 its own line straight to the primary controller. This direct route is turned on and off per source through a separate set/clear enable register. The summary path and the direct path run side by side: a source can reach the primary controller both ways at once.

Software reaches the block through a word-addressed register port. The port has a write strobe, a read strobe, a byte offset and 32-bit data. The word index is the offset divided by four. Each enable register is changed only through a set port and a clear port, so no read-modify-write is needed. A soft-interrupt pair of ports gives direct control of mask bit 0.

Top module: `sic_top`

## Requirements
- R1: `irq_sum_o` is high exactly when the bitwise AND of the sampled source levels and the enable mask is non-zero. It reflects a source change one clock edge after the change.
- R2: A read returns data one clock edge after the read strobe. Index 0 returns the raw levels AND the enable mask. Index 1 returns the raw sampled levels. Index 2 returns the enable mask.
- R3: A write to index 2 ORs the data into the enable mask. A write to index 3 clears each mask bit that is written as 1.
- R4: A write of any non-zero value to index 4 sets mask bit 0. A write of any non-zero value to index 5 clears mask bit 0. A zero value written to either index changes nothing. A read of index 4 returns raw level bit 0 in bit 0 and zeros in all other bits.
- R5: A write to index 8 sets direct-route enable bits only inside field 0x7FE00000 (sources 21 to 30). All other written bits are dropped. A read of index 8 returns the direct-route enable register.
- R6: A write to index 9 clears each direct-route enable bit that is written as 1.
- R7: `irq_pt_o[i]` equals the level of source 21+i, one edge after the source changes, while that source's direct-route enable is set. It is low while the enable is clear.
- R8: Reads of any index other than 0, 1, 2, 4 and 8 return zero. This includes offsets with any bit set above the 4-bit index. Writes to any index other than 2, 3, 4, 5, 8 and 9 change no state.
- R9: Synchronous active-high reset clears the enable mask, the direct-route enables, the read data and every interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (12) | Byte offset; word index is bus_addr[ADDR_W-1:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one edge after bus_rd |
| src_i | input | 32 | Level-sensitive interrupt sources |
| irq_sum_o | output | 1 | Summary request to the primary controller |
| irq_pt_o | output | PT_HI-PT_LO+1 (10) | Direct-route lines for sources 21 to 30 |

## Verification
A source change reaches `irq_sum_o`, `irq_pt_o` and the raw-level register on the first rising edge after the change. A register write takes effect at its own edge, so its effect on the outputs appears one edge later. Read data appears on the edge that samples the read strobe. The bench drives and samples on falling edges. It samples an output once right after a source change, to confirm the old value still holds. It samples again after exactly one rising edge, to confirm the new value. After each configuring write it waits one extra edge before it compares the outputs.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int SRC_W = 32;
    localparam int IDX_W = 4;

    typedef logic [SRC_W-1:0] word_t;

    typedef enum logic [IDX_W-1:0] {
        RI_STATUS   = 4'd0,
        RI_RAW      = 4'd1,
        RI_EN_SET   = 4'd2,
        RI_EN_CLR   = 4'd3,
        RI_SOFT_SET = 4'd4,
        RI_SOFT_CLR = 4'd5,
        RI_PT_SET   = 4'd8,
        RI_PT_CLR   = 4'd9
    } reg_idx_e;

    typedef struct packed {
        logic status;
        logic raw;
        logic en_set;
        logic en_clr;
        logic soft_set;
        logic soft_clr;
        logic pt_set;
        logic pt_clr;
    } reg_sel_t;

    // Bits lo..hi set, all others clear
    function automatic word_t span_mask(int lo, int hi);
        word_t m;
        for (int b = 0; b < SRC_W; b++) begin
            m[b] = (b >= lo) && (b <= hi);
        end
        return m;
    endfunction

    // One-hot register select from the low index bits
    function automatic reg_sel_t sel_of(logic [IDX_W-1:0] idx, logic in_range);
        reg_sel_t s;
        s = '0;
        if (in_range) begin
            case (idx)
                RI_STATUS:   s.status   = 1'b1;
                RI_RAW:      s.raw      = 1'b1;
                RI_EN_SET:   s.en_set   = 1'b1;
                RI_EN_CLR:   s.en_clr   = 1'b1;
                RI_SOFT_SET: s.soft_set = 1'b1;
                RI_SOFT_CLR: s.soft_clr = 1'b1;
                RI_PT_SET:   s.pt_set   = 1'b1;
                RI_PT_CLR:   s.pt_clr   = 1'b1;
                default:     s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/sic_decode.sv
module sic_decode
    import sic_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam int HI_LSB = 2 + IDX_W;

    logic in_range;
    logic unused_byte_lanes;

    assign unused_byte_lanes = ^addr[1:0];

    generate
        if (ADDR_W > HI_LSB) begin : g_upper
            assign in_range = ~|addr[ADDR_W-1:HI_LSB];
        end else begin : g_no_upper
            assign in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        sel = sel_of(addr[HI_LSB-1:2], in_range);
    end

endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int PT_LO = 21,
    parameter int PT_HI = 30
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic     rd_en,
    input  reg_sel_t sel,
    input  word_t    wdata,
    input  word_t    raw,
    output word_t    mask,
    output word_t    pt_en,
    output word_t    rdata
);

    localparam word_t PT_FIELD = span_mask(PT_LO, PT_HI);

    word_t mask_nxt;
    word_t pt_nxt;
    word_t rd_mux;

    always_comb begin
        mask_nxt = mask;
        pt_nxt   = pt_en;
        if (wr_en) begin
            if (sel.en_set)                mask_nxt = mask | wdata;
            if (sel.en_clr)                mask_nxt = mask & ~wdata;
            if (sel.soft_set && |wdata)    mask_nxt = mask | word_t'(1);
            if (sel.soft_clr && |wdata)    mask_nxt = mask & ~word_t'(1);
            if (sel.pt_set)                pt_nxt   = pt_en | (wdata & PT_FIELD);
            if (sel.pt_clr)                pt_nxt   = pt_en & ~wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel.status)   rd_mux = raw & mask;
        if (sel.raw)      rd_mux = raw;
        if (sel.en_set)   rd_mux = mask;
        if (sel.soft_set) rd_mux = word_t'(raw[0]);
        if (sel.pt_set)   rd_mux = pt_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '0;
            pt_en <= '0;
            rdata <= '0;
        end else begin
            mask  <= mask_nxt;
            pt_en <= pt_nxt;
            if (rd_en) rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/sic_route.sv
module sic_route
    import sic_pkg::*;
#(
    parameter int PT_LO = 21,
    parameter int PT_HI = 30,
    localparam int PT_N = PT_HI - PT_LO + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  word_t           src,
    input  word_t           mask,
    input  logic [PT_N-1:0] pt_en,
    output word_t           raw_q,
    output logic            sum_q,
    output logic [PT_N-1:0] pt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            sum_q <= 1'b0;
        end else begin
            raw_q <= src;
            sum_q <= |(src & mask);
        end
    end

    generate
        for (genvar i = 0; i < PT_N; i++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) pt_q[i] <= 1'b0;
                else     pt_q[i] <= src[PT_LO+i] & pt_en[i];
            end
        end
    endgenerate

endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PT_LO  = 21,
    parameter int PT_HI  = 30,
    localparam int PT_N  = PT_HI - PT_LO + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       src_i,
    output logic              irq_sum_o,
    output logic [PT_N-1:0]   irq_pt_o
);

    reg_sel_t sel;
    word_t    en_mask;
    word_t    pt_en;
    word_t    raw_lvl;

    sic_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    sic_regs #(.PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .rd_en (bus_rd),
        .sel   (sel),
        .wdata (bus_wdata),
        .raw   (raw_lvl),
        .mask  (en_mask),
        .pt_en (pt_en),
        .rdata (bus_rdata)
    );

    sic_route #(.PT_LO(PT_LO), .PT_HI(PT_HI)) u_route (
        .clk   (clk),
        .rst   (rst),
        .src   (src_i),
        .mask  (en_mask),
        .pt_en (pt_en[PT_HI:PT_LO]),
        .raw_q (raw_lvl),
        .sum_q (irq_sum_o),
        .pt_q  (irq_pt_o)
    );

endmodule

// File: rtl/sic_chk.sv
module sic_chk #(
    parameter int ADDR_W = 12,
    parameter int PT_LO  = 21,
    parameter int PT_HI  = 30,
    localparam int PT_N  = PT_HI - PT_LO + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       src,
    input logic              irq,
    input logic [PT_N-1:0]   pt,
    input logic [31:0]       mask,
    input logic [31:0]       pt_en
);

    logic [ADDR_W-3:0] widx;
    logic              wr_known;
    logic [31:0]       field;

    assign widx     = addr[ADDR_W-1:2];
    assign wr_known = (widx == 2) || (widx == 3) || (widx == 4) ||
                      (widx == 5) || (widx == 8) || (widx == 9);

    always_comb begin
        for (int b = 0; b < 32; b++) field[b] = (b >= PT_LO) && (b <= PT_HI);
    end

    // R1
    summary_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq == |($past(src) & $past(mask)));

    // R3
    enset_or_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && widx == 2) |=> (mask & $past(wdata)) == $past(wdata));

    // R4
    soft_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && widx == 4 && wdata != 0) |=> mask[0]);

    // R5
    pt_field_only_chk: assert property (@(posedge clk) disable iff (rst)
        (pt_en & ~field) == 32'h0);

    // R7
    pt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pt == ($past(src[PT_HI:PT_LO]) & $past(pt_en[PT_HI:PT_LO])));

    // R8
    unknown_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !wr_known) |=> ($stable(mask) && $stable(pt_en)));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && pt == '0 && mask == 32'h0 && pt_en == 32'h0));

endmodule

bind sic_top sic_chk #(.ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .src   (src_i),
    .irq   (irq_sum_o),
    .pt    (irq_pt_o),
    .mask  (en_mask),
    .pt_en (pt_en)
);

// File: tb/sic_top_tb.sv
module sic_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int PT_N       = 10;

    typedef struct packed {
        logic [31:0]     mask;
        logic [31:0]     pt;
        logic [31:0]     src;
        logic            sum;
        logic [PT_N-1:0] pt_exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 10'h000},
        '{32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b1, 10'h000},
        '{32'h8000_0000, 32'h0000_0000, 32'h7FFF_FFFF, 1'b0, 10'h000},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0020_0000, 1'b1, 10'h001},
        '{32'h0000_0000, 32'h4000_0000, 32'h4000_0000, 1'b0, 10'h200},
        '{32'h00F0_0000, 32'h8010_0000, 32'hC010_0000, 1'b1, 10'h000},
        '{32'h0000_0000, 32'h7FE0_0000, 32'h5540_0000, 1'b0, 10'h2AA}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       src_i = '0;
    logic              irq_sum_o;
    logic [PT_N-1:0]   irq_pt_o;

    int n_chk  = 0;
    int n_fail = 0;

    sic_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_i     (src_i),
        .irq_sum_o (irq_sum_o),
        .irq_pt_o  (irq_pt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check("R9 sum", 32'(irq_sum_o), 32'h0);
        check("R9 pt", 32'(irq_pt_o), 32'h0);
        rd(12'h008, v); check("R9 mask", v, 32'h0);
        rd(12'h020, v); check("R9 pt_en", v, 32'h0);

        // Vector table: R1 R2 R3 R5 R7
        foreach (VECS[k]) begin
            wr(12'h00C, 32'hFFFF_FFFF);
            wr(12'h008, VECS[k].mask);
            wr(12'h024, 32'hFFFF_FFFF);
            wr(12'h020, VECS[k].pt);
            src_i = VECS[k].src;
            tick();
            check("R1 sum", 32'(irq_sum_o), 32'(VECS[k].sum));
            check("R7 pt", 32'(irq_pt_o), 32'(VECS[k].pt_exp));
            rd(12'h000, v); check("R2 status", v, VECS[k].src & VECS[k].mask);
            rd(12'h004, v); check("R2 raw", v, VECS[k].src);
            rd(12'h008, v); check("R3 mask", v, VECS[k].mask);
            rd(12'h020, v); check("R5 pt_en", v, VECS[k].pt & 32'h7FE0_0000);
        end

        // R4 soft interrupt ports
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h010, 32'h0);
        rd(12'h008, v); check("R4 zero set ignored", v, 32'h0);
        wr(12'h010, 32'h0000_0005);
        rd(12'h008, v); check("R4 soft set", v, 32'h1);
        wr(12'h014, 32'h0);
        rd(12'h008, v); check("R4 zero clr ignored", v, 32'h1);
        src_i = 32'hFFFF_FFFE; tick();
        rd(12'h010, v); check("R4 soft read 0", v, 32'h0);
        src_i = 32'h0000_0001; tick();
        rd(12'h010, v); check("R4 soft read 1", v, 32'h1);
        wr(12'h014, 32'h8000_0000);
        rd(12'h008, v); check("R4 soft clr", v, 32'h0);

        // R3 partial set and clear
        wr(12'h008, 32'h0000_F0F0);
        wr(12'h008, 32'h0000_0F00);
        rd(12'h008, v); check("R3 or set", v, 32'h0000_FFF0);
        wr(12'h00C, 32'h0000_00F0);
        rd(12'h008, v); check("R3 clear", v, 32'h0000_FF00);

        // R8 unknown offsets
        wr(12'h024, 32'hFFFF_FFFF);
        wr(12'h020, 32'h0200_0000);
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h408, 32'hFFFF_FFFF);
        wr(12'h03C, 32'hFFFF_FFFF);
        rd(12'h008, v); check("R8 mask kept", v, 32'h0000_FF00);
        rd(12'h020, v); check("R8 pt kept", v, 32'h0200_0000);
        rd(12'h018, v); check("R8 read idx6", v, 32'h0);
        rd(12'h00C, v); check("R8 read idx3", v, 32'h0);
        rd(12'h024, v); check("R8 read idx9", v, 32'h0);
        rd(12'h408, v); check("R8 read high", v, 32'h0);

        // R7 latency and disable
        src_i = 32'h0; tick();
        check("R7 idle", 32'(irq_pt_o), 32'h0);
        src_i = 32'h0200_0000;
        check("R7 before edge", 32'(irq_pt_o), 32'h0);
        tick();
        check("R7 after edge", 32'(irq_pt_o), 32'h010);
        wr(12'h024, 32'h0200_0000);
        tick();
        check("R7 disabled low", 32'(irq_pt_o), 32'h0);
        rd(12'h020, v); check("R6 pt clr", v, 32'h0);

        // R1 latency
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h008, 32'h0000_0100);
        src_i = 32'h0; tick();
        check("R1 idle", 32'(irq_sum_o), 32'h0);
        src_i = 32'h0000_0100;
        check("R1 before edge", 32'(irq_sum_o), 32'h0);
        tick();
        check("R1 after edge", 32'(irq_sum_o), 32'h1);

        // R9 reset mid-run
        wr(12'h020, 32'hFFFF_FFFF);
        src_i = 32'hFFFF_FFFF; tick();
        check("R9 pre sum", 32'(irq_sum_o), 32'h1);
        rst = 1'b1; tick(); rst = 1'b0;
        check("R9 sum", 32'(irq_sum_o), 32'h0);
        check("R9 pt", 32'(irq_pt_o), 32'h0);
        check("R9 rdata", bus_rdata, 32'h0);
        rd(12'h008, v); check("R9 mask", v, 32'h0);
        rd(12'h020, v); check("R9 pt_en", v, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule